// File: doc/BRIEF.md
# Register-Mapped MDIO Management Master

This block lets a host processor talk to external Ethernet PHYs over the two-wire MDIO management bus using Clause 22 frames. Software sees three 32-bit word registers. A single write to the command word carries the whole transaction: PHY address, register address, write data, the operation and a valid bit that launches it. The block then generates the management clock from the system clock and shifts out a 64-bit frame on the data line. It takes the line back during a read and captures the PHY's answer.

Software polls the status word until the busy flag is clear, writes a command, and polls again until busy clears. After a read it then fetches the data word. That word holds the 16-bit register value in its low half and a two-bit error indication above it. The error is raised when the PHY fails to take control of the line during turnaround. Malformed commands, and commands written while a frame is in flight, are discarded silently.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the status word and the data word read as 0, MDC is low and the MDIO output enable is low.
- R2: Byte offset 0x0 is the status word, with busy in bit 3. Busy reads as 1 in a status read issued in the cycle after an accepted command write. Offset 0x8 is the command word. Offset 0xC is the data word. Register reads return data one cycle after the read strobe.
- R3: Command bit 31 is the valid bit. Bits 29:25 hold the PHY address, bits 24:20 the register address and bits 19:4 the write data. Bit 1 requests a write and bit 2 requests a read. A write frame is 32 ones, start 01, opcode 01, PHY address, register address, turnaround 1 then 0, and the 16 data bits, all MSB first.
- R4: A read frame uses opcode 10 and drives the same leading fields. The master releases MDIO (output enable low) for both turnaround bits and all 16 data bits. The 16 sampled bits appear in bits 15:0 of the data word, MSB first.
- R5: If MDIO is high when sampled in the second turnaround bit of a read, data-word bits 17:16 read 11. Otherwise they read 00. The flags are refreshed by every read.
- R6: A command write that arrives while busy is high is ignored. No extra frame starts, and the data word is left unchanged.
- R7: A valid command with both operation bits set, or with neither set, starts no frame and leaves busy low.
- R8: The master changes MDIO and its output enable only on the system-clock edge where MDC falls. Read data is sampled on the edge where MDC rises.
- R9: While a frame runs, MDC has a period of 2×DIV_HALF system clocks. MDC is low whenever the block is idle.
- R10: Busy clears one system clock after the MDC falling edge that ends the 64th bit. A status read strobed in the cycle of that falling edge still shows busy, and one strobed a cycle later shows it clear.
- R11: A command write with bit 31 clear starts no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The command decoder and the frame engine's completion can act in the same system-clock cycle. The case is a command write landing on the very edge at which busy drops. The bench waits for the falling MDC edge that closes the final bit and drives a command write in that same cycle. It expects the command to be discarded, because busy was still set when the write was decoded. No further frame may appear, and the status word must then read idle. A separate frame probes the same boundary with status reads strobed in that cycle and in the next, to pin down exactly when busy clears.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int PHY_AW       = 5;
  localparam int REG_AW       = 5;
  localparam int DATA_W       = 16;
  localparam int PREAMBLE_LEN = 32;
  localparam int FRAME_LEN    = PREAMBLE_LEN + 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;
  localparam int IDX_W        = $clog2(FRAME_LEN);
  localparam int TA_POS       = FRAME_LEN - DATA_W - 2;

  localparam logic [3:0] OFS_STATUS = 4'h0;
  localparam logic [3:0] OFS_CMD    = 4'h8;
  localparam logic [3:0] OFS_DATA   = 4'hC;

  localparam int CMD_VALID_BIT = 31;
  localparam int CMD_PHY_LSB   = 25;
  localparam int CMD_REG_LSB   = 20;
  localparam int CMD_WDATA_LSB = 4;
  localparam int CMD_WR_BIT    = 1;
  localparam int CMD_RD_BIT    = 2;
  localparam int STAT_BUSY_BIT = 3;

  typedef struct packed {
    logic              is_read;
    logic [PHY_AW-1:0] phy;
    logic [REG_AW-1:0] regad;
    logic [DATA_W-1:0] wdata;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_now,
  output logic fall_now
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = run && (cnt == CNT_END);
  assign rise_now = wrap && !mdc;
  assign fall_now = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9: once the engine stops, the clock is parked low
  a_r9_stopped_low: assert property (@(posedge clk) disable iff (rst)
    $past(!run) |-> !mdc);
endmodule

// File: rtl/mdio_cmd_decode.sv
module mdio_cmd_decode
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  input  logic        done,
  output logic        busy,
  output logic        start,
  output mdio_cmd_t   cmd
);
  logic op_ok;
  logic accept;
  logic unused_bits;

  assign op_ok  = wdata[CMD_WR_BIT] ^ wdata[CMD_RD_BIT];
  assign accept = wr_en && (addr == OFS_CMD) && wdata[CMD_VALID_BIT] && op_ok && !busy;
  assign unused_bits = ^{wdata[30], wdata[3], wdata[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      start <= 1'b0;
      cmd   <= '0;
    end else begin
      start <= accept;
      if (accept) begin
        busy          <= 1'b1;
        cmd.is_read   <= wdata[CMD_RD_BIT];
        cmd.phy       <= wdata[CMD_PHY_LSB +: PHY_AW];
        cmd.regad     <= wdata[CMD_REG_LSB +: REG_AW];
        cmd.wdata     <= wdata[CMD_WDATA_LSB +: DATA_W];
      end else if (done) begin
        busy <= 1'b0;
      end
    end
  end

  // R6: a launch only ever follows an idle cycle
  a_r6_start_from_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> !$past(busy));

  // R7: a launched command carried exactly one operation bit
  a_r7_one_op: assert property (@(posedge clk) disable iff (rst)
    start |-> ($past(wdata[CMD_WR_BIT]) != $past(wdata[CMD_RD_BIT])));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic              rise_now,
  input  logic              fall_now,
  input  logic              mdio_i,
  output logic              active,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_err
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA1_IDX  = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(TA_POS + 1);
  localparam logic [IDX_W-1:0] D0_IDX   = IDX_W'(TA_POS + 2);

  logic [FRAME_LEN-1:0] sh;
  logic [FRAME_LEN-1:0] frame;
  logic [IDX_W-1:0]     idx;
  logic [IDX_W-1:0]     nidx;
  logic                 is_rd;

  assign nidx  = idx + 1'b1;
  assign frame = {{PREAMBLE_LEN{1'b1}}, 2'b01,
                  (cmd.is_read ? 2'b10 : 2'b01),
                  cmd.phy, cmd.regad,
                  (cmd.is_read ? 2'b11 : 2'b10),
                  (cmd.is_read ? {DATA_W{1'b1}} : cmd.wdata)};

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      idx     <= '0;
      sh      <= '0;
      is_rd   <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      rd_done <= 1'b0;
      rd_data <= '0;
      rd_err  <= 1'b0;
    end else begin
      done    <= 1'b0;
      rd_done <= 1'b0;
      if (start) begin
        active  <= 1'b1;
        idx     <= '0;
        sh      <= frame;
        is_rd   <= cmd.is_read;
        mdio_o  <= frame[FRAME_LEN-1];
        mdio_oe <= 1'b1;
        rd_err  <= 1'b0;
      end else if (active && fall_now) begin
        if (idx == LAST_IDX) begin
          active  <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
          done    <= 1'b1;
          rd_done <= is_rd;
        end else begin
          idx     <= nidx;
          sh      <= {sh[FRAME_LEN-2:0], 1'b0};
          mdio_o  <= sh[FRAME_LEN-2];
          mdio_oe <= !(is_rd && (nidx >= TA1_IDX));
        end
      end else if (active && rise_now && is_rd) begin
        if (idx == TA2_IDX) rd_err <= mdio_i;
        if (idx >= D0_IDX) rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      end
    end
  end

  // R8: outside launch and MDC falling edges the pin drive holds still
  a_r8_change_on_fall: assert property (@(posedge clk) disable iff (rst)
    ($past(active) && !$past(start) && !$past(fall_now)) |->
      ($stable(mdio_o) && $stable(mdio_oe)));

  // R4: the master is not driving during the last data bit of a read
  a_r4_released_tail: assert property (@(posedge clk) disable iff (rst)
    (active && is_rd && idx == LAST_IDX) |-> !mdio_oe);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int PAD_W = 32 - DATA_W - 2;

  logic              busy;
  logic              start;
  mdio_cmd_t         cmd;
  logic              active;
  logic              rise_now;
  logic              fall_now;
  logic              done;
  logic              rd_done;
  logic [DATA_W-1:0] rd_data;
  logic              rd_err;
  logic [31:0]       data_word;

  mdio_cmd_decode u_dec (
    .clk   (clk),
    .rst   (rst),
    .wr_en (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .done  (done),
    .busy  (busy),
    .start (start),
    .cmd   (cmd)
  );

  mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .run      (active),
    .mdc      (mdc),
    .rise_now (rise_now),
    .fall_now (fall_now)
  );

  mdio_frame_engine u_eng (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cmd      (cmd),
    .rise_now (rise_now),
    .fall_now (fall_now),
    .mdio_i   (mdio_i),
    .active   (active),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (done),
    .rd_done  (rd_done),
    .rd_data  (rd_data),
    .rd_err   (rd_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_word <= '0;
    end else if (rd_done) begin
      data_word <= {{PAD_W{1'b0}}, rd_err, rd_err, rd_data};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFS_STATUS: reg_rdata <= 32'(busy) << STAT_BUSY_BIT;
        OFS_DATA:   reg_rdata <= data_word;
        default:    reg_rdata <= '0;
      endcase
    end
  end

  // R2: busy only rises after a command write with the valid bit
  a_r2_busy_after_cmd: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_wr && reg_addr == OFS_CMD && reg_wdata[CMD_VALID_BIT]));

  // R10: the master drives the line only inside a busy window
  a_r10_oe_within_busy: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy);

  // R9: the management clock is parked low while idle
  a_r9_mdc_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);
endmodule

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int frames = 0;

  typedef struct {
    logic [63:0] bits;
    logic [63:0] oe;
    logic        ta_bad;
    logic [15:0] val;
  } exp_t;
  exp_t exp_q[$];
  exp_t cur;
  event last_fall;

  always #2 clk = ~clk;

  mdio_mgmt_master #(.DIV_HALF(DIV)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  bit in_frame = 0;
  int nrise = 0;
  int bad_bits = 0;
  int bad_period = 0;
  int bad_hold = 0;
  int last_rise = 0;
  logic mdc_p = 0, o_p = 1, oe_p = 0;

  function automatic logic phy_bit(input int i);
    if (cur.oe[63-i]) return 1'b1;
    if (i == 46) return 1'b1;
    if (i == 47) return cur.ta_bad;
    return cur.val[15-(i-48)];
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (!in_frame && mdio_oe) begin
        in_frame = 1; nrise = 0; frames++;
        bad_bits = 0; bad_period = 0; bad_hold = 0;
        if (exp_q.size() == 0) begin
          check(0, "R6/R7/R11 unexpected frame", 32'd1, 32'd0);
          cur.bits = '1; cur.oe = '1; cur.ta_bad = 0; cur.val = 0;
        end else cur = exp_q.pop_front();
      end else if (in_frame) begin
        if (mdc && mdc_p && (mdio_o !== o_p || mdio_oe !== oe_p)) bad_hold++;
        if (mdc && !mdc_p) begin
          if (mdio_oe !== cur.oe[63-nrise] || (cur.oe[63-nrise] && mdio_o !== cur.bits[63-nrise]))
            bad_bits++;
          if (nrise > 0 && (cyc - last_rise) != 2*DIV) bad_period++;
          last_rise = cyc;
          nrise++;
        end
        if (!mdc && mdc_p) begin
          if (nrise == 64) begin
            in_frame = 0;
            mdio_i = 1'b1;
            check(bad_bits == 0, "R3/R4 frame bits", bad_bits, 0);
            check(bad_period == 0 && bad_hold == 0, "R9/R8 MDC period and hold", bad_period + bad_hold, 0);
            ->last_fall;
          end else mdio_i = phy_bit(nrise);
        end
      end
    end
    mdc_p = mdc; o_p = mdio_o; oe_p = mdio_oe;
  end

  // bus driver
  task automatic wr_now(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask
  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_now(a, d);
  endtask
  task automatic rd_now(input logic [3:0] a, output logic [31:0] v);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    v = reg_rdata;
  endtask
  task automatic bus_read(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_now(a, v);
  endtask

  function automatic logic [31:0] cmd_word(input bit v, input bit rd, input bit wr,
                                           input logic [4:0] phy, input logic [4:0] ra,
                                           input logic [15:0] d);
    return {v, 1'b0, phy, ra, d, 1'b0, rd, wr, 1'b0};
  endfunction

  task automatic push_exp(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                          input logic [15:0] d, input bit ta_bad);
    exp_t e;
    e.bits = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, (rd ? 18'h0 : {2'b10, d})};
    e.oe = rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : '1;
    e.ta_bad = ta_bad;
    e.val = d;
    exp_q.push_back(e);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      bus_read(4'h0, s);
      if (s[3] == 1'b0) break;
    end
  endtask

  task automatic run_txn(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] d, input bit ta_bad, input logic [31:0] exp_data);
    logic [31:0] s;
    push_exp(rd, phy, ra, d, ta_bad);
    bus_write(4'h8, cmd_word(1, rd, !rd, phy, ra, rd ? 16'h0 : d));
    rd_now(4'h0, s);
    check(s == 32'h8, "R2 busy after command", s, 32'h8);
    wait_idle();
    if (rd) begin
      bus_read(4'hC, s);
      check(s == exp_data, rd ? (ta_bad ? "R5 error flags" : "R4 read data") : "R3", s, exp_data);
    end
  endtask

  initial begin
    logic [31:0] v;
    int f0;
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset state
    check(mdc == 0 && mdio_oe == 0, "R1 pins after reset", {mdc, mdio_oe}, 0);
    bus_read(4'h0, v); check(v == 0, "R1 status after reset", v, 0);
    bus_read(4'hC, v); check(v == 0, "R1 data after reset", v, 0);

    // R3 write frame, R4 read, R5 error flags and refresh
    run_txn(0, 5'h1A, 5'h03, 16'hA5C3, 0, 0);
    run_txn(1, 5'h05, 5'h11, 16'hBEEF, 0, 32'h0000_BEEF);
    run_txn(1, 5'h1F, 5'h00, 16'h1234, 1, 32'h0003_1234);
    run_txn(1, 5'h00, 5'h1F, 16'h0F0F, 0, 32'h0000_0F0F);
    check(frames == 4, "R3 frame count", frames, 4);

    // R6 command while busy is ignored
    push_exp(0, 5'h02, 5'h04, 16'h5555, 0);
    bus_write(4'h8, cmd_word(1, 0, 1, 5'h02, 5'h04, 16'h5555));
    repeat (40) @(negedge clk);
    wr_now(4'h8, cmd_word(1, 1, 0, 5'h09, 5'h09, 16'h0));
    wait_idle();
    repeat (300) @(negedge clk);
    check(frames == 5, "R6 no extra frame", frames, 5);
    bus_read(4'hC, v); check(v == 32'h0000_0F0F, "R6 data word unchanged", v, 32'h0000_0F0F);

    // R7 both or neither operation bits
    bus_write(4'h8, cmd_word(1, 1, 1, 5'h01, 5'h01, 16'h1111));
    rd_now(4'h0, v); check(v == 0, "R7 both ops, busy low", v, 0);
    bus_write(4'h8, cmd_word(1, 0, 0, 5'h01, 5'h01, 16'h1111));
    rd_now(4'h0, v); check(v == 0, "R7 no op, busy low", v, 0);
    // R11 valid bit clear
    bus_write(4'h8, cmd_word(0, 0, 1, 5'h01, 5'h01, 16'h1111));
    rd_now(4'h0, v); check(v == 0, "R11 no valid, busy low", v, 0);
    repeat (300) @(negedge clk);
    check(frames == 5, "R7/R11 no frame started", frames, 5);

    // R10 busy clears one clock after final falling edge
    push_exp(0, 5'h0C, 5'h0A, 16'h8001, 0);
    bus_write(4'h8, cmd_word(1, 0, 1, 5'h0C, 5'h0A, 16'h8001));
    @(last_fall);
    rd_now(4'h0, v); check(v == 32'h8, "R10 busy still set at last fall", v, 32'h8);
    rd_now(4'h0, v); check(v == 0, "R10 busy clear one clock later", v, 0);

    // R6 command landing in the completion cycle
    push_exp(1, 5'h11, 5'h02, 16'hC3A5, 0);
    bus_write(4'h8, cmd_word(1, 1, 0, 5'h11, 5'h02, 16'h0));
    @(last_fall);
    f0 = frames;
    wr_now(4'h8, cmd_word(1, 0, 1, 5'h07, 5'h07, 16'h7777));
    repeat (300) @(negedge clk);
    check(frames == f0, "R6 completion-cycle command dropped", frames, f0);
    bus_read(4'h0, v); check(v == 0, "R6 idle after dropped command", v, 0);
    bus_read(4'hC, v); check(v == 32'h0000_C3A5, "R4 read data", v, 32'h0000_C3A5);

    // back-to-back accepted after idle
    run_txn(0, 5'h15, 5'h15, 16'h0001, 0, 0);
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule